// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable behavioural model of a single-clock synchronous static RAM with late-write timing. Each rising clock edge samples an address, an active-low select, an active-low write enable and four active-low lane write enables. The 36-bit word is split into four 9-bit lanes. A write command is accepted at one edge, and its data is taken from the data input at the following edge. Read data is registered at the command edge and presented in the next cycle.

The write data arrives one cycle after its address, so it lands in a pending-write register that holds an address, a lane mask and a data word. The pending entry is committed to the storage array when the next write data arrives or when a cycle carries no access. Until then, a read to the same address merges the pending lanes into the returned word. A read that immediately follows a write command also merges the write data that is arriving at that edge.

The data bus is modelled as a separate input, an output and an output-drive enable. An active-low output enable and an active-high sleep input gate the drive enable asynchronously. Commands sampled during sleep or while deselected cause no access. The depth is a parameter.

Top module: `lw_sram_core`

## Requirements
- R1: After reset is released, `dq_oe` is low until a read command has been accepted, and no earlier write is pending.
- R2: A read command (`sel_n`=0, `wen_n`=1, `sleep`=0) at edge k drives `dq_oe` high and `dq_o` to the stored word for the whole cycle after edge k, provided `oe_n`=0 and `sleep`=0 in that cycle. Reads issued on consecutive edges return one word per cycle.
- R3: A write command (`sel_n`=0, `wen_n`=0, `sleep`=0) at edge k leaves `dq_oe` low in the cycle after edge k. The write data is taken from `dq_i` at edge k+1. Lane i of the word is bits [9i+8:9i], and it is controlled by `lane_wen_n[i]`.
- R4: On a write, only the lanes whose `lane_wen_n` bit is 0 change. Any of the 16 lane combinations is legal.
- R5: A read returns every earlier write in command order, including a write whose data has not yet been committed to the array and a write whose data arrives at the same edge as the read.
- R6: With `sel_n`=1 at an edge, no access happens: the stored data is unchanged whatever the other inputs are, and `dq_oe` is low in the next cycle.
- R7: `oe_n`=1 forces `dq_oe` low in the same cycle without waiting for a clock edge. A read accepted while `oe_n` is high (a dummy read) drives nothing.
- R8: `sleep`=1 forces `dq_oe` low at once. A command sampled while `sleep`=1 causes no access.
- R9: `dq_oe` is never high in a cycle whose edge-ending data is write data, so the bus never contends at a read-to-write or write-to-read turnaround.
- R10: A write command with all four `lane_wen_n` bits at 1 leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every sample is taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| sleep | input | 1 | Active-high sleep; blocks commands and the output drive |
| sel_n | input | 1 | Active-low select; high gives a deselect cycle |
| wen_n | input | 1 | Active-low write enable; high gives a read |
| lane_wen_n | input | LANES (4) | Active-low write enable per 9-bit lane |
| addr | input | AW (10) | Word address |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dq_i | input | 36 | Data bus input; write data one cycle after the write command |
| dq_o | output | 36 | Registered read data |
| dq_oe | output | 1 | Data bus drive enable; low means high impedance |

## Verification
A pending entry that is lost, committed to the wrong address or committed with the wrong mask does not show up at the port that holds it. It shows up as a wrong lane in `dq_o` at the first later read of that address, one cycle after that read command. The bench therefore keeps a small set of addresses hot, so such reads follow within a few cycles. A wrong read-valid or write-phase flag shows up on `dq_oe` in the very next cycle, either as a missing word or as a drive during a write-data cycle. Mask and merge errors show up as single 9-bit lanes that differ from the reference word.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;

   // Command decoded from the sampled control pins
   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_RD  = 2'd1,
      CMD_WR  = 2'd2
   } lw_cmd_e;

endpackage

// File: rtl/lw_cmd_decode.sv
`timescale 1ns/1ps
module lw_cmd_decode
   import lw_sram_pkg::*;
(
   input  logic    sleep,
   input  logic    sel_n,
   input  logic    wen_n,
   output lw_cmd_e cmd
);

   always_comb begin
      if (sleep || sel_n) cmd = CMD_NOP;   // sleep and deselect both mean no access
      else if (wen_n)     cmd = CMD_RD;
      else                cmd = CMD_WR;
   end

endmodule

// File: rtl/lw_late_write_buf.sv
`timescale 1ns/1ps
module lw_late_write_buf
   import lw_sram_pkg::*;
#(
   parameter int AW     = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  lw_cmd_e                 cmd,
   input  logic [AW-1:0]           addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*LANE_W-1:0] din,
   output logic                    cap_valid,
   output logic [AW-1:0]           cap_addr,
   output logic [LANES-1:0]        cap_mask,
   output logic                    pend_valid,
   output logic [AW-1:0]           pend_addr,
   output logic [LANES-1:0]        pend_mask,
   output logic [LANES*LANE_W-1:0] pend_data,
   output logic                    commit_en
);

   localparam int WORD_W = LANES * LANE_W;

   logic [WORD_W-1:0] din_masked;

   // Lanes that are not written are zeroed before they reach the pending register
   for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
      assign din_masked[g*LANE_W +: LANE_W] = cap_mask[g] ? din[g*LANE_W +: LANE_W] : '0;
   end

   // The pending entry drains when new write data replaces it or the cycle is idle
   assign commit_en = pend_valid && (cap_valid || (cmd == CMD_NOP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid  <= 1'b0;
         cap_addr   <= '0;
         cap_mask   <= '0;
         pend_valid <= 1'b0;
         pend_addr  <= '0;
         pend_mask  <= '0;
         pend_data  <= '0;
      end else begin
         cap_valid <= (cmd == CMD_WR);
         if (cmd == CMD_WR) begin
            cap_addr <= addr;
            cap_mask <= lane_we;
         end
         if (cap_valid) begin
            pend_valid <= |cap_mask;
            pend_addr  <= cap_addr;
            pend_mask  <= cap_mask;
            pend_data  <= din_masked;
         end else if (commit_en) begin
            pend_valid <= 1'b0;
         end
      end
   end

   // R4: an entry that is waiting always carries at least one lane
   p_pend_has_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (pend_mask != '0));

   // R10: a write with every lane disabled leaves no entry waiting
   p_empty_mask_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && (cap_mask == '0)) |=> !pend_valid);

endmodule

// File: rtl/lw_mem_array.sv
`timescale 1ns/1ps
module lw_mem_array #(
   parameter int DEPTH  = 1024,
   parameter int AW     = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [LANES-1:0]        wmask,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [AW-1:0]           raddr,
   output logic [LANES*LANE_W-1:0] rdata
);

   // One storage column per lane so each lane has its own write strobe
   for (genvar g = 0; g < LANES; g++) begin : g_lane_col
      logic [LANE_W-1:0] col [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[g]) col[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = col[raddr];
   end

endmodule

// File: rtl/lw_read_path.sv
`timescale 1ns/1ps
module lw_read_path #(
   parameter int AW     = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_cmd,
   input  logic [AW-1:0]           raddr,
   input  logic [LANES*LANE_W-1:0] arr_word,
   input  logic                    pend_valid,
   input  logic [AW-1:0]           pend_addr,
   input  logic [LANES-1:0]        pend_mask,
   input  logic [LANES*LANE_W-1:0] pend_data,
   input  logic                    cap_valid,
   input  logic [AW-1:0]           cap_addr,
   input  logic [LANES-1:0]        cap_mask,
   input  logic [LANES*LANE_W-1:0] din,
   input  logic                    oe_n,
   input  logic                    sleep,
   output logic [LANES*LANE_W-1:0] dq_o,
   output logic                    dq_oe
);

   localparam int WORD_W = LANES * LANE_W;

   logic              hit_pend;
   logic              hit_cap;
   logic [WORD_W-1:0] merged;
   logic              rd_q;
   logic [WORD_W-1:0] rd_data_q;

   assign hit_pend = pend_valid && (pend_addr == raddr);
   assign hit_cap  = cap_valid  && (cap_addr  == raddr);

   // Newest source wins: arriving write data, then the pending entry, then the array
   for (genvar g = 0; g < LANES; g++) begin : g_merge
      always_comb begin
         merged[g*LANE_W +: LANE_W] = arr_word[g*LANE_W +: LANE_W];
         if (hit_pend && pend_mask[g]) merged[g*LANE_W +: LANE_W] = pend_data[g*LANE_W +: LANE_W];
         if (hit_cap && cap_mask[g])   merged[g*LANE_W +: LANE_W] = din[g*LANE_W +: LANE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         rd_data_q <= '0;
      end else begin
         rd_q <= rd_cmd;
         if (rd_cmd) rd_data_q <= merged;
      end
   end

   assign dq_o  = rd_data_q;
   assign dq_oe = rd_q && !oe_n && !sleep;

endmodule

// File: rtl/lw_sram_core.sv
`timescale 1ns/1ps
module lw_sram_core
   import lw_sram_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int WORD_W = LANES * LANE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              sel_n,
   input  logic              wen_n,
   input  logic [LANES-1:0]  lane_wen_n,
   input  logic [AW-1:0]     addr,
   input  logic              oe_n,
   input  logic [WORD_W-1:0] dq_i,
   output logic [WORD_W-1:0] dq_o,
   output logic              dq_oe
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("lw_sram_core: DEPTH must be at least 2");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("lw_sram_core: LANES and LANE_W must be positive");
   end

   lw_cmd_e           cmd;
   logic              cap_valid;
   logic [AW-1:0]     cap_addr;
   logic [LANES-1:0]  cap_mask;
   logic              pend_valid;
   logic [AW-1:0]     pend_addr;
   logic [LANES-1:0]  pend_mask;
   logic [WORD_W-1:0] pend_data;
   logic              commit_en;
   logic [WORD_W-1:0] arr_word;

   lw_cmd_decode i_dec (
      .sleep (sleep),
      .sel_n (sel_n),
      .wen_n (wen_n),
      .cmd   (cmd)
   );

   lw_late_write_buf #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_lwb (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .addr       (addr),
      .lane_we    (~lane_wen_n),
      .din        (dq_i),
      .cap_valid  (cap_valid),
      .cap_addr   (cap_addr),
      .cap_mask   (cap_mask),
      .pend_valid (pend_valid),
      .pend_addr  (pend_addr),
      .pend_mask  (pend_mask),
      .pend_data  (pend_data),
      .commit_en  (commit_en)
   );

   lw_mem_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
      .clk   (clk),
      .we    (commit_en),
      .waddr (pend_addr),
      .wmask (pend_mask),
      .wdata (pend_data),
      .raddr (addr),
      .rdata (arr_word)
   );

   lw_read_path #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_rdp (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_cmd     (cmd == CMD_RD),
      .raddr      (addr),
      .arr_word   (arr_word),
      .pend_valid (pend_valid),
      .pend_addr  (pend_addr),
      .pend_mask  (pend_mask),
      .pend_data  (pend_data),
      .cap_valid  (cap_valid),
      .cap_addr   (cap_addr),
      .cap_mask   (cap_mask),
      .din        (dq_i),
      .oe_n       (oe_n),
      .sleep      (sleep),
      .dq_o       (dq_o),
      .dq_oe      (dq_oe)
   );

   // R2: an accepted read drives the bus in the next cycle unless gated off
   p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !sel_n && wen_n) |=> (dq_oe || oe_n || sleep));

   // R3: the cycle after a write command leaves the bus undriven
   p_write_cmd_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !sel_n && !wen_n) |=> !dq_oe);

   // R6: a deselected edge leads to an undriven bus
   p_deselect_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> !dq_oe);

   // R8: a command sampled in sleep never produces a drive
   p_sleep_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !dq_oe);

   // R9: write data cycles and read drive cycles never overlap
   p_no_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> !dq_oe);

   // R1: nothing is pending in the first cycle after reset
   p_reset_clean_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!pend_valid && !dq_oe));

endmodule

// File: tb/test_lw_sram_core.sv
`timescale 1ns/1ps
module test_lw_sram_core;

   localparam int DEPTH = 1024;
   localparam int AW    = 10;
   localparam int WW    = 36;
   localparam int K_NOP = 0;
   localparam int K_RD  = 1;
   localparam int K_WR  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep = 1'b0;
   logic          sel_n = 1'b1;
   logic          wen_n = 1'b1;
   logic [3:0]    lane_wen_n = 4'hF;
   logic [AW-1:0] addr = '0;
   logic          oe_n = 1'b0;
   logic [WW-1:0] dq_i = '0;
   logic [WW-1:0] dq_o;
   logic          dq_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [WW-1:0] ref_mem [DEPTH];

   int            prev_kind = K_NOP;
   logic [WW-1:0] prev_data = '0;
   logic [WW-1:0] prev_exp  = '0;
   string         prev_tag  = "R1";

   always #2 clk = ~clk;

   lw_sram_core i_lw_sram_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep      (sleep),
      .sel_n      (sel_n),
      .wen_n      (wen_n),
      .lane_wen_n (lane_wen_n),
      .addr       (addr),
      .oe_n       (oe_n),
      .dq_i       (dq_i),
      .dq_o       (dq_o),
      .dq_oe      (dq_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected word after a late write with active-low lane enables
   function automatic logic [WW-1:0] apply_lanes(input logic [WW-1:0] old, input logic [WW-1:0] d, input logic [3:0] m_n);
      logic [WW-1:0] r = old;
      for (int i = 0; i < 4; i++)
         if (!m_n[i]) r[i*9 +: 9] = d[i*9 +: 9];
      return r;
   endfunction

   // One clock cycle: check the outcome of the previous edge, supply late data, issue a new command
   task automatic step(input int kind, input logic [AW-1:0] a, input logic [3:0] m_n,
                       input logic [WW-1:0] d, input logic oe, input logic slp, input string tag);
      bit exp_oe;
      int eff;
      @(negedge clk);
      exp_oe = (prev_kind == K_RD) && !oe_n && !sleep;
      chk(dq_oe == exp_oe, {prev_tag, " drive enable"}, {35'd0, dq_oe}, {35'd0, exp_oe});
      if (exp_oe && dq_oe) chk(dq_o == prev_exp, {prev_tag, " read data"}, dq_o, prev_exp);
      if (prev_kind == K_WR) chk(!dq_oe, "R9 no drive in write data cycle", {35'd0, dq_oe}, '0);
      dq_i = (prev_kind == K_WR) ? prev_data : {$urandom(), $urandom()};
      eff = slp ? K_NOP : kind;
      sleep = slp;
      oe_n  = oe;
      addr  = a;
      lane_wen_n = m_n;
      sel_n = (kind == K_NOP);
      wen_n = (kind != K_WR);
      if (kind == K_NOP) wen_n = $urandom_range(0, 1);
      if (eff == K_RD) prev_exp = ref_mem[a];
      if (eff == K_WR) ref_mem[a] = apply_lanes(ref_mem[a], d, m_n);
      prev_kind = eff;
      prev_data = d;
      prev_tag  = tag;
   endtask

   task automatic rnd_word(output logic [WW-1:0] w);
      w = {$urandom(), $urandom()};
   endtask

   initial begin
      logic [WW-1:0] w;
      logic [WW-1:0] w2;
      void'($urandom(32'h0051_A7E5));
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1: bus undriven during and just after reset
      chk(dq_oe == 1'b0, "R1 reset drive enable", {35'd0, dq_oe}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dq_oe == 1'b0, "R1 after reset drive enable", {35'd0, dq_oe}, '0);

      // Fill the hot addresses and the top address with full words
      for (int i = 0; i < 16; i++) begin
         rnd_word(w);
         step(K_WR, AW'(i), 4'h0, w, 1'b0, 1'b0, "R3");
      end
      rnd_word(w);
      step(K_WR, AW'(DEPTH-1), 4'h0, w, 1'b0, 1'b0, "R3");

      // R2: back-to-back reads stream one word per cycle
      for (int i = 0; i < 16; i++) step(K_RD, AW'(i), 4'hF, '0, 1'b0, 1'b0, "R2");
      step(K_RD, AW'(DEPTH-1), 4'hF, '0, 1'b0, 1'b0, "R2");

      // R4: every lane combination, each followed by a read
      for (int m = 0; m < 16; m++) begin
         rnd_word(w);
         step(K_WR, AW'(3), 4'(m), w, 1'b0, 1'b0, "R4");
         step(K_NOP, '0, 4'hF, '0, 1'b0, 1'b0, "R4");
         step(K_RD, AW'(3), 4'hF, '0, 1'b0, 1'b0, "R4");
      end

      // R5: read right after the write command (data arriving at the same edge)
      rnd_word(w);
      step(K_WR, AW'(5), 4'b1010, w, 1'b0, 1'b0, "R5");
      step(K_RD, AW'(5), 4'hF, '0, 1'b0, 1'b0, "R5");
      // R5: pending entry plus newer write to another address, then read both
      rnd_word(w); rnd_word(w2);
      step(K_WR, AW'(6), 4'b0110, w, 1'b0, 1'b0, "R5");
      step(K_WR, AW'(7), 4'b0001, w2, 1'b0, 1'b0, "R5");
      step(K_RD, AW'(6), 4'hF, '0, 1'b0, 1'b0, "R5");
      step(K_RD, AW'(7), 4'hF, '0, 1'b0, 1'b0, "R5");
      // R5: two writes to one address, read while the first is pending
      rnd_word(w); rnd_word(w2);
      step(K_WR, AW'(8), 4'b1100, w, 1'b0, 1'b0, "R5");
      step(K_WR, AW'(8), 4'b1001, w2, 1'b0, 1'b0, "R5");
      step(K_RD, AW'(8), 4'hF, '0, 1'b0, 1'b0, "R5");

      // R10: all lane enables high leaves the word unchanged
      rnd_word(w);
      step(K_WR, AW'(9), 4'hF, w, 1'b0, 1'b0, "R10");
      step(K_RD, AW'(9), 4'hF, '0, 1'b0, 1'b0, "R10");

      // R6: deselect with write enable low does not write
      @(negedge clk);
      rnd_word(w);
      step(K_NOP, AW'(10), 4'h0, w, 1'b0, 1'b0, "R6");
      wen_n = 1'b0;
      step(K_RD, AW'(10), 4'hF, '0, 1'b0, 1'b0, "R6");

      // R7: dummy read with output enable high, then async gating of a real read
      step(K_RD, AW'(11), 4'hF, '0, 1'b1, 1'b0, "R7");
      step(K_RD, AW'(11), 4'hF, '0, 1'b0, 1'b0, "R7");
      @(posedge clk); #0.5;
      chk(dq_oe == 1'b1, "R7 drive before gating", {35'd0, dq_oe}, 36'd1);
      oe_n = 1'b1; #0.5;
      chk(dq_oe == 1'b0, "R7 async output enable", {35'd0, dq_oe}, '0);
      oe_n = 1'b0; #0.5;
      chk(dq_oe == 1'b1, "R7 drive restored", {35'd0, dq_oe}, 36'd1);

      // R8: write attempted in sleep is ignored; sleep gates a read at once
      rnd_word(w);
      step(K_WR, AW'(12), 4'h0, w, 1'b0, 1'b1, "R8");
      step(K_RD, AW'(12), 4'hF, '0, 1'b0, 1'b0, "R8");
      step(K_RD, AW'(13), 4'hF, '0, 1'b0, 1'b0, "R8");
      @(posedge clk); #0.5;
      sleep = 1'b1; #0.5;
      chk(dq_oe == 1'b0, "R8 async sleep", {35'd0, dq_oe}, '0);
      sleep = 1'b0;

      // Random mix over the hot addresses
      for (int n = 0; n < 4000; n++) begin
         int r;
         int k;
         logic oe;
         logic slp;
         r   = $urandom_range(0, 99);
         k   = (r < 45) ? K_RD : (r < 85) ? K_WR : K_NOP;
         oe  = ($urandom_range(0, 9) == 0);
         slp = ($urandom_range(0, 19) == 0);
         rnd_word(w);
         step(k, AW'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), w, oe, slp,
              (k == K_WR) ? "R4" : (k == K_RD) ? "R5" : "R6");
      end
      // Drain and read every hot address
      for (int i = 0; i < 16; i++) step(K_RD, AW'(i), 4'hF, '0, 1'b0, 1'b0, "R5");
      step(K_NOP, '0, 4'hF, '0, 1'b0, 1'b0, "R6");
      step(K_NOP, '0, 4'hF, '0, 1'b0, 1'b0, "R6");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule